// File: doc/BRIEF.md
# One-Wire Accessory Identification Sequencer

This block drives the single-wire identification line of an accessory connector. It plays a byte sequence that a host has loaded, and that sequence tells the far end what kind of accessory is attached. Every bit is sent as an active-low pulse inside a fixed slot. The pulse width carries the bit value. The slot length and both pulse widths come from host-written counts. The host can also ask for a line reset: a long low pulse, then a released recovery gap.

The block also owns the two connector pins, the ID wire and the power wire. After reset both pins belong to the sequencer, and the power pin is left undriven. Once a sequence has finished, the host sets a sticky handover bit. From then on the ID pin carries the serial-wire debug data signal in both directions, and the power pin carries the debug clock driven by the debug engine. Only a line-reset command or the global reset gives the pins back to the sequencer.

Host access uses a Wishbone-style classic bus with 8-bit data. A request is acknowledged one cycle after it is accepted. The byte buffer sits at addresses 0 to DEPTH-1. The command/status register sits at DEPTH. The length and the timing counts (short pulse, long pulse, slot, reset low, reset gap) follow at DEPTH+1 through DEPTH+6.

Top module: `idwire_seq`

## Requirements
- R1: After reset the ID pin is released (`pad_id_oe`=0), the power pin is undriven (`pad_pwr_oe`=0), `dbg_swdio_i` reads 1, and the status register (address DEPTH) reads 0x00.
- R2: Buffer bytes (addresses 0..DEPTH-1) and the timing counts (DEPTH+2..DEPTH+6) read back the values written. `bus_ack` is high for exactly one cycle per request, one cycle after acceptance.
- R3: Bits go out LSB first, one slot of T_BIT cycles each. A 1 is a low pulse of T_ONE cycles (DEPTH+2) and a 0 is a low pulse of T_ZERO cycles (DEPTH+3), both at the start of the slot. The first slot begins in the cycle after the start command is accepted.
- R4: A start command (write bit 0 at DEPTH) plays exactly LEN bytes (DEPTH+1), from buffer address 0 upward. When the last slot ends, status reads busy=0, done=1. Status bits are busy in bit 0, done in bit 1, handover in bit 2. With LEN=0 the block sets done without any pulse.
- R5: Busy reads 1 while a playback or a line reset runs. Start and line-reset commands written while busy are ignored.
- R6: A line-reset command (write bit 1 at DEPTH) drives the ID pin low for T_RST cycles (DEPTH+5) and then releases it for T_REC cycles (DEPTH+6) while busy. It clears done and handover.
- R7: A handover request (write bit 2 at DEPTH) sets handover only when done=1 and the block is idle. While handover is set, start commands are ignored.
- R8: With handover set, `pad_id_o`/`pad_id_oe` follow `dbg_swdio_o`/`dbg_swdio_oe`, `dbg_swdio_i` follows `pad_id_i`, and the power pin is driven with `dbg_swclk`.
- R9: Loading 0x75, 0xA0 with LEN=2 produces the debug-cable identification waveform: 16 slots whose pulse widths decode back to those two bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cyc | input | 1 | Bus cycle |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Write enable |
| bus_adr | input | AW | Register address |
| bus_dat_i | input | 8 | Write data |
| bus_dat_o | output | 8 | Read data, valid with ack |
| bus_ack | output | 1 | Acknowledge |
| pad_id_i | input | 1 | ID pin input level |
| pad_id_o | output | 1 | ID pin output level |
| pad_id_oe | output | 1 | ID pin output enable |
| pad_pwr_o | output | 1 | Power pin output level |
| pad_pwr_oe | output | 1 | Power pin output enable |
| dbg_swdio_o | input | 1 | Debug data from debug engine |
| dbg_swdio_oe | input | 1 | Debug data enable from debug engine |
| dbg_swdio_i | output | 1 | Debug data to debug engine |
| dbg_swclk | input | 1 | Debug clock from debug engine |

## Verification
The assertions assume the host sets LEN no higher than DEPTH. They also assume the host makes T_BIT larger than both pulse widths and touches neither the buffer nor the timing counts while busy. The assertions relating busy and handover to commands take for granted that bus requests follow the classic single-transfer pattern and drop strobe after ack. The directed stimulus loads every count and byte while the block is idle, uses pulse widths strictly below the slot length, and issues commands during a playback only to check that they are ignored.

// File: rtl/idwire_seq.sv
module idwire_seq #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cyc,
  input  logic          bus_stb,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_adr,
  input  logic [7:0]    bus_dat_i,
  output logic [7:0]    bus_dat_o,
  output logic          bus_ack,
  input  logic          pad_id_i,
  output logic          pad_id_o,
  output logic          pad_id_oe,
  output logic          pad_pwr_o,
  output logic          pad_pwr_oe,
  input  logic          dbg_swdio_o,
  input  logic          dbg_swdio_oe,
  output logic          dbg_swdio_i,
  input  logic          dbg_swclk
);
  localparam int IW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_CTRL  = AW'(DEPTH);
  localparam logic [AW-1:0] A_LEN   = AW'(DEPTH + 1);
  localparam logic [AW-1:0] A_TONE  = AW'(DEPTH + 2);
  localparam logic [AW-1:0] A_TZERO = AW'(DEPTH + 3);
  localparam logic [AW-1:0] A_TBIT  = AW'(DEPTH + 4);
  localparam logic [AW-1:0] A_TRST  = AW'(DEPTH + 5);
  localparam logic [AW-1:0] A_TREC  = AW'(DEPTH + 6);

  typedef enum logic [1:0] {S_IDLE, S_BIT, S_RLOW, S_RGAP} st_t;

  st_t           st;
  logic [7:0]    mem [DEPTH];
  logic [LW-1:0] len_q;
  logic [7:0]    t_one, t_zero, t_bit, t_rst, t_rec;
  logic [7:0]    cnt;
  logic [2:0]    bit_i;
  logic [LW-1:0] byte_i;
  logic          done_q, hand_q, ack_q;
  logic [7:0]    rdat_q, rd;

  wire req     = bus_cyc & bus_stb & ~ack_q;
  wire wr      = req & bus_we;
  wire ctrl_wr = wr && (bus_adr == A_CTRL);
  wire busy    = (st != S_IDLE);
  wire rcmd    = ctrl_wr & bus_dat_i[1] & ~busy;
  wire go      = ctrl_wr & bus_dat_i[0] & ~bus_dat_i[1] & ~busy & ~hand_q;
  wire hset    = ctrl_wr & bus_dat_i[2] & ~bus_dat_i[1] & ~busy & done_q;

  wire [7:0] cur_byte = mem[byte_i[IW-1:0]];
  wire [7:0] width    = cur_byte[bit_i] ? t_one : t_zero;
  wire [8:0] cnt_nx   = {1'b0, cnt} + 9'd1;
  wire slot_end = cnt_nx >= {1'b0, t_bit};
  wire rlow_end = cnt_nx >= {1'b0, t_rst};
  wire rgap_end = cnt_nx >= {1'b0, t_rec};
  wire last_byte = (byte_i == LW'(len_q - LW'(1)));
  wire seq_low  = ((st == S_BIT) && (cnt < width)) || (st == S_RLOW);

  assign bus_ack     = ack_q;
  assign bus_dat_o   = rdat_q;
  assign pad_id_o    = hand_q ? dbg_swdio_o  : 1'b0;
  assign pad_id_oe   = hand_q ? dbg_swdio_oe : seq_low;
  assign pad_pwr_o   = hand_q ? dbg_swclk    : 1'b0;
  assign pad_pwr_oe  = hand_q;
  assign dbg_swdio_i = hand_q ? pad_id_i     : 1'b1;

  always_comb begin
    rd = 8'h00;
    if (bus_adr < A_CTRL) rd = mem[bus_adr[IW-1:0]];
    else begin
      case (bus_adr)
        A_CTRL:  rd = {5'b0, hand_q, done_q, busy};
        A_LEN:   rd = 8'(len_q);
        A_TONE:  rd = t_one;
        A_TZERO: rd = t_zero;
        A_TBIT:  rd = t_bit;
        A_TRST:  rd = t_rst;
        A_TREC:  rd = t_rec;
        default: rd = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      rdat_q <= 8'h00;
      len_q  <= '0;
      t_one  <= 8'd4;
      t_zero <= 8'd12;
      t_bit  <= 8'd16;
      t_rst  <= 8'd32;
      t_rec  <= 8'd16;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else begin
      ack_q <= req;
      if (req) rdat_q <= rd;
      if (wr) begin
        if (bus_adr < A_CTRL) mem[bus_adr[IW-1:0]] <= bus_dat_i;
        else begin
          case (bus_adr)
            A_LEN:   len_q  <= bus_dat_i[LW-1:0];
            A_TONE:  t_one  <= bus_dat_i;
            A_TZERO: t_zero <= bus_dat_i;
            A_TBIT:  t_bit  <= bus_dat_i;
            A_TRST:  t_rst  <= bus_dat_i;
            A_TREC:  t_rec  <= bus_dat_i;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= 8'd0;
      bit_i  <= 3'd0;
      byte_i <= '0;
      done_q <= 1'b0;
      hand_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (rcmd) begin
            st     <= S_RLOW;
            cnt    <= 8'd0;
            done_q <= 1'b0;
            hand_q <= 1'b0;
          end else if (go) begin
            cnt    <= 8'd0;
            bit_i  <= 3'd0;
            byte_i <= '0;
            if (len_q == '0) done_q <= 1'b1;
            else begin
              done_q <= 1'b0;
              st     <= S_BIT;
            end
          end else if (hset) hand_q <= 1'b1;
        end
        S_BIT: begin
          if (slot_end) begin
            cnt <= 8'd0;
            if (bit_i == 3'd7) begin
              bit_i <= 3'd0;
              if (last_byte) begin
                st     <= S_IDLE;
                done_q <= 1'b1;
              end else byte_i <= byte_i + LW'(1);
            end else bit_i <= bit_i + 3'd1;
          end else cnt <= cnt + 8'd1;
        end
        S_RLOW: begin
          if (rlow_end) begin
            st  <= S_RGAP;
            cnt <= 8'd0;
          end else cnt <= cnt + 8'd1;
        end
        default: begin
          if (rgap_end) st <= S_IDLE;
          else cnt <= cnt + 8'd1;
        end
      endcase
    end
  end
endmodule

// File: rtl/idwire_seq_chk.sv
module idwire_seq_chk #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_cyc,
  input logic          bus_stb,
  input logic          bus_we,
  input logic [AW-1:0] bus_adr,
  input logic          bus_ack,
  input logic          busy,
  input logic          done,
  input logic          hand,
  input logic          pad_id_oe,
  input logic          pad_pwr_oe
);
  logic ctrl_wr;
  assign ctrl_wr = bus_cyc && bus_stb && bus_we && !bus_ack && (bus_adr == AW'(DEPTH));

  assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !hand) |-> !pad_id_oe);

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_from_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctrl_wr));

  assert_reset_drops_handover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hand) |-> busy);

  assert_handover_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hand) |-> $past(done));

  assert_handover_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hand |-> (pad_pwr_oe && !busy));
endmodule

bind idwire_seq idwire_seq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
  .bus_adr(bus_adr), .bus_ack(bus_ack), .busy(busy), .done(done_q), .hand(hand_q),
  .pad_id_oe(pad_id_oe), .pad_pwr_oe(pad_pwr_oe)
);

// File: tb/idwire_seq_bench.sv
`timescale 1ns/1ps
module idwire_seq_bench;
  localparam int DEPTH = 16;
  localparam int AW = 5;
  localparam int A_CTRL = 16, A_LEN = 17, A_TONE = 18, A_TZERO = 19,
                 A_TBIT = 20, A_TRST = 21, A_TREC = 22;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_cyc = 0, bus_stb = 0, bus_we = 0;
  logic [AW-1:0] bus_adr = '0;
  logic [7:0] bus_dat_i = 8'h00, bus_dat_o;
  logic bus_ack;
  logic pad_id_i = 1'b0, pad_id_o, pad_id_oe, pad_pwr_o, pad_pwr_oe;
  logic dbg_swdio_o = 1'b0, dbg_swdio_oe = 1'b0, dbg_swdio_i, dbg_swclk = 1'b0;

  int nvec = 0, nbad = 0;
  int exp_b [16];
  logic lg [0:4095];

  idwire_seq #(.DEPTH(DEPTH)) u_idwire_seq (
    .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_adr(bus_adr), .bus_dat_i(bus_dat_i), .bus_dat_o(bus_dat_o), .bus_ack(bus_ack),
    .pad_id_i(pad_id_i), .pad_id_o(pad_id_o), .pad_id_oe(pad_id_oe),
    .pad_pwr_o(pad_pwr_o), .pad_pwr_oe(pad_pwr_oe), .dbg_swdio_o(dbg_swdio_o),
    .dbg_swdio_oe(dbg_swdio_oe), .dbg_swdio_i(dbg_swdio_i), .dbg_swclk(dbg_swclk));

  always #2 clk = ~clk;

  always @(negedge clk) lg[int'(($time / 4) % 4096)] = pad_id_oe;

  function automatic longint cyc_now();
    return longint'($time / 4);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int adr, input int dat);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_adr = AW'(adr); bus_dat_i = 8'(dat);
    @(negedge clk);
    bus_cyc = 0; bus_stb = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input int adr, output int dat);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_adr = AW'(adr);
    @(negedge clk);
    chk("R2 ack", int'(bus_ack), 1);
    dat = int'(bus_dat_o);
    bus_cyc = 0; bus_stb = 0;
    @(negedge clk);
    chk("R2 ack single", int'(bus_ack), 0);
  endtask

  task automatic set_timing(input int tone, input int tz, input int tb);
    bus_wr(A_TONE, tone); bus_wr(A_TZERO, tz); bus_wr(A_TBIT, tb);
  endtask

  task automatic verify_play(input longint t0, input int nb, input int tone,
                             input int tz, input int tb, input string tag);
    int n = nb * 8 * tb;
    int bad = 0;
    int st;
    while (cyc_now() <= t0 + n + 1) @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      int dec = 0;
      for (int i = 0; i < 8; i++) begin
        int w = ((exp_b[b] >> i) & 1) ? tone : tz;
        int lows = 0;
        for (int k = 0; k < tb; k++) begin
          logic s = lg[int'((t0 + (b * 8 + i) * tb + k) % 4096)];
          if (s) lows++;
          if (s != (k < w)) bad++;
        end
        if (lows == tone) dec |= (1 << i);
      end
      chk({tag, " decoded byte"}, dec, exp_b[b]);
    end
    chk({tag, " waveform mismatches"}, bad, 0);
    chk({tag, " released after last slot"}, int'(lg[int'((t0 + n) % 4096)]), 0);
    bus_rd(A_CTRL, st);
    chk({tag, " status done"}, st, 8'h02);
  endtask

  task automatic t_reset();
    int st;
    chk("R1 id pin released", int'(pad_id_oe), 0);
    chk("R1 pwr pin undriven", int'(pad_pwr_oe), 0);
    pad_id_i = 1'b0;
    #1 chk("R1 swdio_i idle high", int'(dbg_swdio_i), 1);
    bus_rd(A_CTRL, st);
    chk("R1 status zero", st, 0);
  endtask

  task automatic t_regs();
    int v;
    bus_wr(3, 8'h5A);
    bus_wr(DEPTH - 1, 8'hC3);
    bus_wr(A_TREC, 8'h27);
    bus_rd(3, v);          chk("R2 buffer readback", v, 8'h5A);
    bus_rd(DEPTH - 1, v);  chk("R2 last buffer readback", v, 8'hC3);
    bus_rd(A_TREC, v);     chk("R2 timing readback", v, 8'h27);
  endtask

  task automatic t_debug_seq();
    longint t0;
    exp_b[0] = 8'h75; exp_b[1] = 8'hA0;
    bus_wr(0, exp_b[0]); bus_wr(1, exp_b[1]);
    bus_wr(A_LEN, 2);
    set_timing(2, 6, 10);
    bus_wr(A_CTRL, 1);
    t0 = cyc_now();
    verify_play(t0, 2, 2, 6, 10, "R9 R3 debug sequence");
  endtask

  task automatic t_full();
    longint t0;
    for (int i = 0; i < DEPTH; i++) begin
      exp_b[i] = (i * 37 + 11) & 255;
      bus_wr(i, exp_b[i]);
    end
    bus_wr(A_LEN, DEPTH);
    set_timing(1, 3, 4);
    bus_wr(A_CTRL, 1);
    t0 = cyc_now();
    verify_play(t0, DEPTH, 1, 3, 4, "R4 full buffer");
  endtask

  task automatic t_len0();
    longint t0;
    int st, lows = 0;
    bus_wr(A_LEN, 0);
    bus_wr(A_CTRL, 1);
    t0 = cyc_now();
    repeat (22) @(negedge clk);
    for (int k = 0; k < 20; k++) if (lg[int'((t0 + k) % 4096)]) lows++;
    chk("R4 len zero no pulse", lows, 0);
    bus_rd(A_CTRL, st);
    chk("R4 len zero done", st, 8'h02);
  endtask

  task automatic t_busy();
    longint t0;
    int st, lows = 0;
    exp_b[0] = 8'h00;
    bus_wr(0, 0);
    bus_wr(A_LEN, 1);
    set_timing(3, 6, 10);
    bus_wr(A_CTRL, 1);
    t0 = cyc_now();
    bus_rd(A_CTRL, st);
    chk("R5 busy during playback", st, 8'h01);
    bus_wr(A_CTRL, 2);
    bus_wr(A_CTRL, 1);
    verify_play(t0, 1, 3, 6, 10, "R5 commands ignored while busy");
    repeat (12) @(negedge clk);
    for (int k = 0; k < 10; k++) if (lg[int'((t0 + 80 + k) % 4096)]) lows++;
    chk("R5 no late reset or replay", lows, 0);
  endtask

  task automatic t_reset_cmd();
    longint t0;
    int st, bad = 0;
    bus_wr(A_TRST, 5);
    bus_wr(A_TREC, 3);
    bus_wr(A_CTRL, 2);
    t0 = cyc_now();
    bus_rd(A_CTRL, st);
    chk("R5 busy during line reset", st, 8'h01);
    repeat (8) @(negedge clk);
    for (int k = 0; k < 12; k++)
      if (lg[int'((t0 + k) % 4096)] != (k < 5)) bad++;
    chk("R6 reset pulse shape", bad, 0);
    bus_rd(A_CTRL, st);
    chk("R6 done cleared", st, 8'h00);
  endtask

  task automatic t_handover();
    longint t0;
    int st, lows = 0;
    bus_wr(A_CTRL, 4);
    bus_rd(A_CTRL, st);
    chk("R7 handover refused before done", st, 8'h00);
    exp_b[0] = 8'h75;
    bus_wr(0, 8'h75);
    bus_wr(A_LEN, 1);
    set_timing(2, 6, 10);
    bus_wr(A_CTRL, 1);
    t0 = cyc_now();
    verify_play(t0, 1, 2, 6, 10, "R3 single byte");
    bus_wr(A_CTRL, 4);
    bus_rd(A_CTRL, st);
    chk("R7 handover set after done", st, 8'h06);
    dbg_swclk = 1'b1; dbg_swdio_oe = 1'b1; dbg_swdio_o = 1'b1; pad_id_i = 1'b0;
    #1;
    chk("R8 pwr pin driven", int'(pad_pwr_oe), 1);
    chk("R8 pwr pin carries clock", int'(pad_pwr_o), 1);
    chk("R8 id pin enable from engine", int'(pad_id_oe), 1);
    chk("R8 id pin data from engine", int'(pad_id_o), 1);
    chk("R8 swdio_i from pin low", int'(dbg_swdio_i), 0);
    dbg_swclk = 1'b0; pad_id_i = 1'b1;
    #1;
    chk("R8 clock follows low", int'(pad_pwr_o), 0);
    chk("R8 swdio_i from pin high", int'(dbg_swdio_i), 1);
    dbg_swdio_oe = 1'b0;
    bus_wr(A_CTRL, 1);
    t0 = cyc_now();
    repeat (12) @(negedge clk);
    for (int k = 0; k < 10; k++) if (lg[int'((t0 + k) % 4096)]) lows++;
    chk("R7 start ignored under handover", lows, 0);
    bus_rd(A_CTRL, st);
    chk("R7 status unchanged", st, 8'h06);
    bus_wr(A_TRST, 4);
    bus_wr(A_TREC, 2);
    bus_wr(A_CTRL, 2);
    repeat (10) @(negedge clk);
    bus_rd(A_CTRL, st);
    chk("R6 reset clears handover", st, 8'h00);
    chk("R6 pwr pin returned", int'(pad_pwr_oe), 0);
  endtask

  initial begin
    #800000;
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_debug_seq();
    t_full();
    t_len0();
    t_busy();
    t_reset_cmd();
    t_handover();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule